// File: doc/BRIEF.md
# Byte/Halfword Pseudo-DMA Data Port

This block lets a CPU move a run of bytes into or out of an internal byte buffer with ordinary 8-bit or 16-bit bus reads and writes. A controller first arms the port with a start index and a byte length. The port then raises its data-request line. Each host access moves one or two bytes at the current buffer pointer. The access also shortens the remaining length and the shared transfer counter by the number of bytes it moved. When the length runs out, the request drops and a single-cycle done pulse tells the controller that the run is finished.

Halfword accesses are big-endian. The byte at the lower buffer index travels in bits 15:8 and the byte after it travels in bits 7:0. The controller fills and inspects the buffer through a separate byte port. It loads the transfer counter through its own load strobe. The running count of bytes moved lets the controller tell an empty transfer from a filled one.

The host side is a valid/ready stream. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is low only in a cycle where the controller is arming or loading the counter, and the host must then hold its access. Read data is not back-pressured. It appears with `rd_valid` one cycle after the read is taken.

Top module: `pdma_port`

## Requirements
- R1: One cycle with `arm_valid` high loads the start index, the pointer and the length, clears `moved`, and from the next cycle drives `drq` high when the length is non-zero. `acc_ready` is low in that cycle.
- R2: A taken byte write stores `acc_wdata[7:0]` at the current pointer and advances the pointer by one.
- R3: A taken 16-bit write (`acc_wide`=1) stores `acc_wdata[15:8]` at the pointer and `acc_wdata[7:0]` at pointer+1, then advances the pointer by two.
- R4: A taken byte read gives `rd_valid` high in the next cycle, with the byte at the pointer in `rd_data[7:0]` and zero in `rd_data[15:8]`.
- R5: A taken 16-bit read returns the byte at the pointer in `rd_data[15:8]` and the byte at pointer+1 in `rd_data[7:0]`.
- R6: Each taken access lowers the remaining length and `xcnt_value` by the number of bytes it moved. The counter saturates at zero. `xcnt_load` sets the counter to `xcnt_load_val`.
- R7: A write taken while the remaining length or `xcnt_value` is zero changes neither the buffer, `moved`, the length nor the counter.
- R8: A read taken while the remaining length is zero returns `rd_data`=0 and changes no state.
- R9: The access that brings the length to zero makes `drq` low and `done` high for exactly one cycle, both from the next cycle. `done` fires at most once per arming, and never for an arming with length zero.
- R10: `moved` equals the current pointer minus the start index, counted in bytes.
- R11: A 16-bit access with one byte left moves only that byte and stops the length at zero. A write stores `acc_wdata[15:8]`. A read returns the byte in `rd_data[15:8]` with `rd_data[7:0]`=0.
- R12: Buffer addresses wrap modulo the depth, so a 16-bit access at the last index uses the last index and index 0.
- R13: `ctl_rdata` shows the byte at `ctl_addr` in the same cycle. `ctl_we` stores `ctl_wdata` there on the clock edge. A host write to the same index in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_valid | input | 1 | Arm the port with a new run |
| arm_start | input | PTR_W | Start index of the run |
| arm_len | input | PTR_W+1 | Byte length of the run (at most the depth) |
| xcnt_load | input | 1 | Load the transfer counter |
| xcnt_load_val | input | CNT_W | Value for the transfer counter |
| xcnt_value | output | CNT_W | Current transfer counter |
| acc_valid | input | 1 | Host access valid |
| acc_ready | output | 1 | Host access can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_wdata | input | 16 | Host write data |
| rd_valid | output | 1 | Read data valid, one cycle after a taken read |
| rd_data | output | 16 | Read data |
| drq | output | 1 | Data request, high while bytes remain |
| done | output | 1 | One-cycle pulse when the run completes |
| moved | output | PTR_W+1 | Bytes moved since arming |
| ctl_we | input | 1 | Controller buffer write |
| ctl_addr | input | PTR_W | Controller buffer index |
| ctl_wdata | input | 8 | Controller write byte |
| ctl_rdata | output | 8 | Buffer byte at `ctl_addr` |

## Verification
The bench builds the block with its defaults: a 64-byte buffer (PTR_W=6) and a 24-bit transfer counter. The small buffer puts the wrap from index 63 to index 0 within a single armed run of two bytes. The wide counter is loaded with small values, so the zero-counter write block and saturation on a 16-bit write with one count left are reached in a few accesses. The mixed byte/halfword sequence ends on an odd remaining length, which brings the single-byte tail of a 16-bit access into reach.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    XB_NONE = 2'd0,
    XB_ONE  = 2'd1,
    XB_TWO  = 2'd2
  } xfer_bytes_e;

  typedef struct packed {
    logic        write;
    logic        wide;
    logic [15:0] wdata;
  } host_acc_t;

  function automatic logic [15:0] pack_read(input xfer_bytes_e nb, input logic wide,
                                            input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] r;
    if (nb == XB_NONE)      r = 16'h0000;
    else if (!wide)         r = {8'h00, b0};
    else if (nb == XB_TWO)  r = {b0, b1};
    else                    r = {b0, 8'h00};
    return r;
  endfunction

endpackage

// File: rtl/pdma_buf.sv
module pdma_buf #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we0,
  input  logic [PTR_W-1:0] h_addr0,
  input  logic [7:0]       h_d0,
  input  logic             h_we1,
  input  logic [PTR_W-1:0] h_addr1,
  input  logic [7:0]       h_d1,
  output logic [7:0]       h_q0,
  output logic [7:0]       h_q1,
  input  logic             c_we,
  input  logic [PTR_W-1:0] c_addr,
  input  logic [7:0]       c_d,
  output logic [7:0]       c_q
);
  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= 8'h00;
      end else if (h_we0 && h_addr0 == PTR_W'(i)) begin
        mem[i] <= h_d0;
      end else if (h_we1 && h_addr1 == PTR_W'(i)) begin
        mem[i] <= h_d1;
      end else if (c_we && c_addr == PTR_W'(i)) begin
        mem[i] <= c_d;
      end
    end
  end

  assign h_q0 = mem[h_addr0];
  assign h_q1 = mem[h_addr1];
  assign c_q  = mem[c_addr];

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [PTR_W-1:0] arm_start,
  input  logic [LEN_W-1:0] arm_len,
  input  logic             take,
  input  logic             is_write,
  input  logic             wide,
  input  logic             xcnt_zero,
  output logic [PTR_W-1:0] addr,
  output xfer_bytes_e      nbytes,
  output logic             drq,
  output logic             done,
  output logic [LEN_W-1:0] moved
);
  logic [LEN_W-1:0] start_q, cur_q, len_q;
  logic             done_q;

  always_comb begin
    if (len_q == '0 || (is_write && xcnt_zero)) nbytes = XB_NONE;
    else if (wide && len_q >= LEN_W'(2))        nbytes = XB_TWO;
    else                                        nbytes = XB_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else if (arm) begin
      start_q <= LEN_W'(arm_start);
      cur_q   <= LEN_W'(arm_start);
      len_q   <= arm_len;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take && nbytes != XB_NONE) begin
        cur_q  <= cur_q + LEN_W'(nbytes);
        len_q  <= len_q - LEN_W'(nbytes);
        done_q <= (len_q == LEN_W'(nbytes));
      end
    end
  end

  assign addr  = cur_q[PTR_W-1:0];
  assign drq   = (len_q != '0);
  assign done  = done_q;
  assign moved = cur_q - start_q;

endmodule

// File: rtl/pdma_xcnt.sv
module pdma_xcnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic [1:0]       dec_amt,
  output logic [CNT_W-1:0] value,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      if (cnt_q < CNT_W'(dec_amt)) cnt_q <= '0;
      else                         cnt_q <= cnt_q - CNT_W'(dec_amt);
    end
  end

  assign value   = cnt_q;
  assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/pdma_port.sv
module pdma_port
  import pdma_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int CNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_valid,
  input  logic [PTR_W-1:0]   arm_start,
  input  logic [PTR_W:0]     arm_len,
  input  logic               xcnt_load,
  input  logic [CNT_W-1:0]   xcnt_load_val,
  output logic [CNT_W-1:0]   xcnt_value,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic               acc_write,
  input  logic               acc_wide,
  input  logic [15:0]        acc_wdata,
  output logic               rd_valid,
  output logic [15:0]        rd_data,
  output logic               drq,
  output logic               done,
  output logic [PTR_W:0]     moved,
  input  logic               ctl_we,
  input  logic [PTR_W-1:0]   ctl_addr,
  input  logic [7:0]         ctl_wdata,
  output logic [7:0]         ctl_rdata
);
  localparam int LEN_W = PTR_W + 1;

  host_acc_t        acc;
  logic             take;
  logic [PTR_W-1:0] addr0, addr1;
  xfer_bytes_e      nbytes;
  logic             xcnt_zero;
  logic [7:0]       q0, q1;
  logic             rd_valid_q;
  logic [15:0]      rd_data_q;

  assign acc       = '{write: acc_write, wide: acc_wide, wdata: acc_wdata};
  assign acc_ready = !arm_valid && !xcnt_load;
  assign take      = acc_valid && acc_ready;
  assign addr1     = addr0 + PTR_W'(1);

  pdma_seq #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm_valid),
    .arm_start (arm_start),
    .arm_len   (arm_len),
    .take      (take),
    .is_write  (acc.write),
    .wide      (acc.wide),
    .xcnt_zero (xcnt_zero),
    .addr      (addr0),
    .nbytes    (nbytes),
    .drq       (drq),
    .done      (done),
    .moved     (moved)
  );

  pdma_xcnt #(.CNT_W(CNT_W)) u_xcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (xcnt_load),
    .load_val (xcnt_load_val),
    .dec      (take && nbytes != XB_NONE),
    .dec_amt  (nbytes),
    .value    (xcnt_value),
    .is_zero  (xcnt_zero)
  );

  pdma_buf #(.PTR_W(PTR_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_we0   (take && acc.write && nbytes != XB_NONE),
    .h_addr0 (addr0),
    .h_d0    (acc.wide ? acc.wdata[15:8] : acc.wdata[7:0]),
    .h_we1   (take && acc.write && nbytes == XB_TWO),
    .h_addr1 (addr1),
    .h_d1    (acc.wdata[7:0]),
    .h_q0    (q0),
    .h_q1    (q1),
    .c_we    (ctl_we),
    .c_addr  (ctl_addr),
    .c_d     (ctl_wdata),
    .c_q     (ctl_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= take && !acc.write;
      if (take && !acc.write) rd_data_q <= pack_read(nbytes, acc.wide, q0, q1);
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/pdma_port_chk.sv
module pdma_port_chk #(
  parameter int LEN_W = 7,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_valid,
  input logic [LEN_W-1:0] arm_len,
  input logic             xcnt_load,
  input logic [CNT_W-1:0] xcnt_value,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_write,
  input logic             acc_wide,
  input logic             rd_valid,
  input logic [15:0]      rd_data,
  input logic             drq,
  input logic             done,
  input logic [LEN_W-1:0] moved
);
  logic take;
  assign take = acc_valid && acc_ready;

  AST_ARM_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    arm_valid && arm_len != '0 |=> drq && moved == '0); // R1

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_write |=> rd_valid); // R4

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && drq && !acc_wide && !(acc_write && xcnt_value == '0) && !xcnt_load
    |=> moved == LEN_W'($past(moved) + LEN_W'(1))
        && xcnt_value == ($past(xcnt_value) == '0 ? '0 : CNT_W'($past(xcnt_value) - CNT_W'(1)))); // R6

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && acc_write && xcnt_value == '0 && !xcnt_load |=> $stable(moved) && xcnt_value == '0); // R7

  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !drq && !arm_valid |=> $stable(moved)); // R7

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_write && !drq |=> rd_valid && rd_data == 16'h0000); // R8

  AST_DONE_DROPS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drq); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind pdma_port pdma_port_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm_valid  (arm_valid),
  .arm_len    (arm_len),
  .xcnt_load  (xcnt_load),
  .xcnt_value (xcnt_value),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_write  (acc_write),
  .acc_wide   (acc_wide),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .drq        (drq),
  .done       (done),
  .moved      (moved)
);

// File: tb/pdma_port_test.sv
`timescale 1ns/1ps
module pdma_port_test;
  localparam int PTR_W = 6;
  localparam int CNT_W = 24;
  localparam int DEPTH = 1 << PTR_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             arm_valid = 1'b0;
  logic [PTR_W-1:0] arm_start = '0;
  logic [PTR_W:0]   arm_len = '0;
  logic             xcnt_load = 1'b0;
  logic [CNT_W-1:0] xcnt_load_val = '0;
  logic [CNT_W-1:0] xcnt_value;
  logic             acc_valid = 1'b0;
  logic             acc_ready;
  logic             acc_write = 1'b0;
  logic             acc_wide = 1'b0;
  logic [15:0]      acc_wdata = '0;
  logic             rd_valid;
  logic [15:0]      rd_data;
  logic             drq;
  logic             done;
  logic [PTR_W:0]   moved;
  logic             ctl_we = 1'b0;
  logic [PTR_W-1:0] ctl_addr = '0;
  logic [7:0]       ctl_wdata = '0;
  logic [7:0]       ctl_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pdma_port #(.PTR_W(PTR_W), .CNT_W(CNT_W)) uut (.*);

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [15:0] wdata;
    logic [15:0] exp_rd;
    logic [6:0]  exp_moved;
    logic [23:0] exp_xcnt;
    logic        exp_drq;
    logic        exp_done;
  } vec_t;

  // Run armed at index 4, length 7, counter 100, buffer prefilled with pat(i).
  localparam vec_t VEC [7] = '{
    '{1'b1, 1'b0, 16'h00A5, 16'h0000, 7'd1, 24'd99, 1'b1, 1'b0}, // R2 byte write
    '{1'b1, 1'b1, 16'h1234, 16'h0000, 7'd3, 24'd97, 1'b1, 1'b0}, // R3 wide write
    '{1'b0, 1'b0, 16'h0000, 16'h0026, 7'd4, 24'd96, 1'b1, 1'b0}, // R4 byte read pat(7)
    '{1'b0, 1'b1, 16'h0000, 16'h292C, 7'd6, 24'd94, 1'b1, 1'b0}, // R5 wide read pat(8),pat(9)
    '{1'b1, 1'b1, 16'hBEEF, 16'h0000, 7'd7, 24'd93, 1'b0, 1'b1}, // R11 tail, R9 done
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 7'd7, 24'd93, 1'b0, 1'b0}, // R8 empty read
    '{1'b1, 1'b0, 16'h0077, 16'h0000, 7'd7, 24'd93, 1'b0, 1'b0}  // R7 empty write
  };

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 3 + 17);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_arm(input int start, input int len);
    @(negedge clk);
    arm_valid = 1'b1;
    arm_start = PTR_W'(start);
    arm_len   = (PTR_W+1)'(len);
    #1 chk(acc_ready == 1'b0, "R1 ready low while arming", 32'(acc_ready), 0);
    @(posedge clk);
    @(negedge clk);
    arm_valid = 1'b0;
  endtask

  task automatic do_load(input int v);
    @(negedge clk);
    xcnt_load = 1'b1;
    xcnt_load_val = CNT_W'(v);
    @(posedge clk);
    @(negedge clk);
    xcnt_load = 1'b0;
  endtask

  task automatic do_acc(input logic wr, input logic wide, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_wide  = wide;
    acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    @(negedge clk);
    ctl_addr = PTR_W'(a);
    #1 v = ctl_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(drq == 1'b0 && done == 1'b0, "R9 reset drq/done", {30'd0, drq, done}, 0);
    chk(moved == '0, "R10 reset moved", 32'(moved), 0);
    chk(xcnt_value == '0 && rd_valid == 1'b0, "R6 reset counter", 32'(xcnt_value), 0);
    rst_n = 1'b1;

    // R13 controller fill and readback
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_addr = PTR_W'(i);
      ctl_wdata = pat(i);
    end
    @(negedge clk);
    ctl_we = 1'b0;
    peek(9, b);
    chk(b == pat(9), "R13 controller readback", 32'(b), 32'(pat(9)));

    do_load(100);
    chk(xcnt_value == 24'd100, "R6 counter load", 32'(xcnt_value), 100);
    do_arm(4, 7);
    chk(drq == 1'b1 && moved == '0, "R1 armed drq and moved", {24'd0, drq, moved}, 32'h80);

    for (int k = 0; k < 7; k++) begin
      do_acc(VEC[k].wr, VEC[k].wide, VEC[k].wdata);
      if (!VEC[k].wr) begin
        chk(rd_valid == 1'b1, "R4 read valid", 32'(rd_valid), 1);
        chk(rd_data == VEC[k].exp_rd, "R5/R8 read data", 32'(rd_data), 32'(VEC[k].exp_rd));
      end
      chk(moved == VEC[k].exp_moved, "R10 moved count", 32'(moved), 32'(VEC[k].exp_moved));
      chk(xcnt_value == VEC[k].exp_xcnt, "R6 counter step", 32'(xcnt_value), 32'(VEC[k].exp_xcnt));
      chk(drq == VEC[k].exp_drq, "R9 drq level", 32'(drq), 32'(VEC[k].exp_drq));
      chk(done == VEC[k].exp_done, "R9 done pulse", 32'(done), 32'(VEC[k].exp_done));
      if (VEC[k].exp_done) begin
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
      end
    end

    peek(4, b);  chk(b == 8'hA5, "R2 byte stored", 32'(b), 32'hA5);
    peek(5, b);  chk(b == 8'h12, "R3 upper byte first", 32'(b), 32'h12);
    peek(6, b);  chk(b == 8'h34, "R3 lower byte next", 32'(b), 32'h34);
    peek(10, b); chk(b == 8'hBE, "R11 tail stores upper", 32'(b), 32'hBE);
    peek(11, b); chk(b == pat(11), "R7 R11 no write past end", 32'(b), 32'(pat(11)));

    // R7 write blocked by zero counter, then R6 saturation
    do_load(0);
    do_arm(20, 4);
    do_acc(1'b1, 1'b0, 16'h00C3);
    chk(moved == '0 && drq == 1'b1, "R7 zero counter blocks write", 32'(moved), 0);
    peek(20, b); chk(b == pat(20), "R7 buffer untouched", 32'(b), 32'(pat(20)));
    do_load(1);
    do_acc(1'b1, 1'b1, 16'h5566);
    chk(moved == 7'd2, "R6 wide write moves two", 32'(moved), 2);
    chk(xcnt_value == '0, "R6 counter saturates", 32'(xcnt_value), 0);

    // R11 wide read with one byte left
    do_arm(30, 1);
    do_acc(1'b0, 1'b1, 16'h0000);
    chk(rd_data == {pat(30), 8'h00}, "R11 tail read", 32'(rd_data), 32'({pat(30), 8'h00}));
    chk(moved == 7'd1 && drq == 1'b0 && done == 1'b1, "R11 stops at zero", {24'd0, drq, moved}, 32'h01);

    // R12 wrap at end of buffer
    do_load(10);
    do_arm(DEPTH - 1, 2);
    do_acc(1'b1, 1'b1, 16'h7788);
    chk(done == 1'b1 && moved == 7'd2, "R12 wrap run completes", 32'(moved), 2);
    peek(DEPTH - 1, b); chk(b == 8'h77, "R12 last index", 32'(b), 32'h77);
    peek(0, b);         chk(b == 8'h88, "R12 wrapped index", 32'(b), 32'h88);

    // R9 zero-length arming raises nothing
    do_arm(40, 0);
    chk(drq == 1'b0 && done == 1'b0, "R9 empty arming", {30'd0, drq, done}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 no later done", 32'(done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule